// File: doc/BRIEF.md
# Correctable Fault Event FIFO Bank

This block gathers correctable-fault events from several independent sources, for example a processor core, an on-chip interconnect and a RAM array. Each source has its own small FIFO. Every accepted event stores the faulting address with its low bits cleared, so the stored value points to the start of the 64-bit word that holds the fault. Software selects a source, reads the oldest stored address and pops it. Software also clears status flags through a write-one-to-clear port that responds only to privileged writes.

Each source has two status flags. The full flag records that the source's FIFO became completely occupied. The overflow flag records that an event arrived while the FIFO was full and was thrown away. The full flags drive a level interrupt that has its own enable. An overflow raises a one-cycle correctable-error event that has a separate enable. Duplicate filtering and bus adaptation belong to the surrounding logic.

Top module: `cfe_fault_fifo_bank`

## Requirements
- R1: After reset every FIFO is empty (`rd_empty` is 1 for every `rd_sel`, `rd_data` is 0), every full and overflow flag is 0, and `full_irq` and `serr_evt` are 0.
- R2: A stored address keeps bits [ADDR_W-1:3] of the incoming address and has bits [2:0] forced to 0.
- R3: For the source chosen by `rd_sel`, `rd_data` shows the oldest stored address. A `rd_pop` pulse removes that entry. Entries leave each source in the order they arrived, and a source's contents are unaffected by traffic to other sources.
- R4: A source's bit in `full_stat` (bit index equals source index) is set at the clock edge that stores the fourth entry. It stays set after entries are popped, until software clears it.
- R5: `full_irq` equals the OR of all `full_stat` bits while `full_irq_en` is 1, and it is 0 while `full_irq_en` is 0.
- R6: An event that arrives at a full FIFO with no pop of that source in the same cycle is discarded. The FIFO contents and order stay unchanged, and the source's `ovf_stat` bit is set.
- R7: `serr_evt` is high for exactly the one cycle after an edge at which at least one event was discarded while `serr_en` was 1. It stays low for discards made while `serr_en` is 0.
- R8: On a full FIFO, a pop and a new event for the same source in one cycle are both accepted. The FIFO stays full with the new address as its newest entry, and no overflow is recorded.
- R9: A cycle with `clr_wr`=1 and `clr_priv`=1 clears the flags whose mask bits are 1. When `clr_priv`=0 the write leaves every flag unchanged. A flag being set and cleared at the same edge ends up set.
- R10: A pop on an empty source is ignored. The source stays empty and later events are stored and read back normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| full_irq_en | input | 1 | Enables the full interrupt |
| serr_en | input | 1 | Enables the overflow error event |
| evt_valid | input | N_SRC | One fault event strobe per source |
| evt_addr | input | N_SRC*ADDR_W | Fault addresses; source s occupies bits [s*ADDR_W +: ADDR_W] |
| rd_sel | input | SEL_W | Source chosen for reading and popping |
| rd_pop | input | 1 | Pops the head entry of the chosen source |
| rd_data | output | ADDR_W | Head entry of the chosen source, 0 when it is empty |
| rd_empty | output | 1 | The chosen source holds no entries |
| clr_wr | input | 1 | Status clear write strobe |
| clr_priv | input | 1 | The clear write is privileged |
| clr_full_mask | input | N_SRC | Full flags to clear, one bit per source |
| clr_ovf_mask | input | N_SRC | Overflow flags to clear, one bit per source |
| full_stat | output | N_SRC | Sticky full flags |
| ovf_stat | output | N_SRC | Sticky overflow flags |
| full_irq | output | 1 | Level full interrupt |
| serr_evt | output | 1 | One-cycle overflow error event |

## Verification
A wrong occupancy count or pointer becomes visible at the ports within one cycle:
- A wrong count makes `full_stat` set at the wrong edge or lets an overflow through, and `ovf_stat` and `serr_evt` report it at the very next edge.
- A wrong pointer makes the next read of `rd_data` return the wrong address.

The bench keeps a small model of every queue and compares all outputs after every edge. Any stale flag or misplaced entry is therefore reported in the cycle it first reaches the outputs. A long pseudo-random phase holds the FIFOs near full, so swaps, drops and clears collide often.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

   // Outcome of one incoming event at a source FIFO
   typedef enum logic [1:0] {
      PUSH_NONE  = 2'd0,
      PUSH_STORE = 2'd1,
      PUSH_SWAP  = 2'd2,
      PUSH_DROP  = 2'd3
   } cfe_push_e;

   // Low address bits cleared for 64-bit word alignment
   localparam int CFE_WORD_LSB = 3;

endpackage

// File: rtl/cfe_src_fifo.sv
module cfe_src_fifo
   import cfe_pkg::*;
#(
   parameter int DEPTH     = 4,
   parameter int ADDR_W    = 32,
   parameter int ALIGN_LSB = CFE_WORD_LSB
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              pop_i,
   output logic [ADDR_W-1:0] head_o,
   output logic              empty_o,
   output cfe_push_e         kind_o,
   output logic              fills_o
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_chk_depth
      $error("cfe_src_fifo: DEPTH must be at least 2");
   end
   if (ALIGN_LSB < 0 || ALIGN_LSB >= ADDR_W) begin : g_chk_align
      $error("cfe_src_fifo: ALIGN_LSB out of range");
   end

   logic [ADDR_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  cnt, cnt_nxt;
   logic [ADDR_W-1:0] wdata;
   logic              is_full, pop_ok, push_ok;

   function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
      return (p == PTR_LAST) ? '0 : p + 1'b1;
   endfunction

   if (ALIGN_LSB == 0) begin : g_no_align
      assign wdata = addr_i;
   end else begin : g_align
      assign wdata = {addr_i[ADDR_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
   end

   assign is_full = (cnt == CNT_FULL);
   assign empty_o = (cnt == '0);
   assign pop_ok  = pop_i && !empty_o;

   always_comb begin
      if (!push_i)      kind_o = PUSH_NONE;
      else if (!is_full) kind_o = PUSH_STORE;
      else if (pop_ok)  kind_o = PUSH_SWAP;
      else              kind_o = PUSH_DROP;
   end

   assign push_ok = (kind_o == PUSH_STORE) || (kind_o == PUSH_SWAP);
   assign cnt_nxt = cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
   assign fills_o = push_ok && (cnt_nxt == CNT_FULL);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_ok) wr_ptr <= ptr_step(wr_ptr);
         if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
         cnt <= cnt_nxt;
      end
   end

   always_ff @(posedge clk_i) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   assign head_o = mem[rd_ptr];

   // R3: occupancy never exceeds the depth
   a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt <= CNT_FULL);

   // R6: a dropped event leaves the FIFO exactly as full as before
   a_r6_drop_keeps_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_o == PUSH_DROP) |=> (cnt == CNT_FULL) && $stable(wr_ptr) && $stable(rd_ptr));

   // R8: a swap on a full FIFO keeps it full
   a_r8_swap_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_o == PUSH_SWAP) |=> (cnt == CNT_FULL));

   // R10: popping an empty FIFO without a push keeps it empty
   a_r10_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && empty_o && !push_i) |=> empty_o && $stable(rd_ptr));

endmodule

// File: rtl/cfe_src_flags.sv
module cfe_src_flags (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fill_i,
   input  logic drop_i,
   input  logic clr_full_i,
   input  logic clr_ovf_i,
   output logic full_o,
   output logic ovf_o
);

   // Setting wins over a clear at the same edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         full_o <= 1'b0;
         ovf_o  <= 1'b0;
      end else begin
         full_o <= fill_i | (full_o & ~clr_full_i);
         ovf_o  <= drop_i | (ovf_o & ~clr_ovf_i);
      end
   end

   // R4: full flag appears the edge the last slot fills
   a_r4_full_on_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fill_i |=> full_o);

   // R4: full flag is sticky without a clear
   a_r4_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o && !clr_full_i) |=> full_o);

   // R6: overflow flag records every drop
   a_r6_ovf_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_i |=> ovf_o);

   // R9: a flag only falls through a clear
   a_r9_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o && !clr_ovf_i) |=> ovf_o);

endmodule

// File: rtl/cfe_fault_fifo_bank.sv
module cfe_fault_fifo_bank
   import cfe_pkg::*;
#(
   parameter int N_SRC     = 3,
   parameter int DEPTH     = 4,
   parameter int ADDR_W    = 32,
   parameter int ALIGN_LSB = CFE_WORD_LSB,
   localparam int SEL_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    full_irq_en,
   input  logic                    serr_en,
   input  logic [N_SRC-1:0]        evt_valid,
   input  logic [N_SRC*ADDR_W-1:0] evt_addr,
   input  logic [SEL_W-1:0]        rd_sel,
   input  logic                    rd_pop,
   output logic [ADDR_W-1:0]       rd_data,
   output logic                    rd_empty,
   input  logic                    clr_wr,
   input  logic                    clr_priv,
   input  logic [N_SRC-1:0]        clr_full_mask,
   input  logic [N_SRC-1:0]        clr_ovf_mask,
   output logic [N_SRC-1:0]        full_stat,
   output logic [N_SRC-1:0]        ovf_stat,
   output logic                    full_irq,
   output logic                    serr_evt
);

   if (N_SRC < 1) begin : g_chk_src
      $error("cfe_fault_fifo_bank: N_SRC must be at least 1");
   end

   logic [ADDR_W-1:0] heads [N_SRC];
   logic [N_SRC-1:0]  empties, fills, drops;
   logic [N_SRC-1:0]  clr_full_en, clr_ovf_en;
   logic              serr_q;

   assign clr_full_en = (clr_wr && clr_priv) ? clr_full_mask : '0;
   assign clr_ovf_en  = (clr_wr && clr_priv) ? clr_ovf_mask  : '0;

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      logic      pop_s;
      cfe_push_e kind_s;

      assign pop_s    = rd_pop && (rd_sel == SEL_W'(s));
      assign drops[s] = (kind_s == PUSH_DROP);

      cfe_src_fifo #(
         .DEPTH    (DEPTH),
         .ADDR_W   (ADDR_W),
         .ALIGN_LSB(ALIGN_LSB)
      ) u_fifo (
         .clk_i  (clk),
         .rst_ni (rst_n),
         .push_i (evt_valid[s]),
         .addr_i (evt_addr[s*ADDR_W +: ADDR_W]),
         .pop_i  (pop_s),
         .head_o (heads[s]),
         .empty_o(empties[s]),
         .kind_o (kind_s),
         .fills_o(fills[s])
      );

      cfe_src_flags u_flags (
         .clk_i     (clk),
         .rst_ni    (rst_n),
         .fill_i    (fills[s]),
         .drop_i    (drops[s]),
         .clr_full_i(clr_full_en[s]),
         .clr_ovf_i (clr_ovf_en[s]),
         .full_o    (full_stat[s]),
         .ovf_o     (ovf_stat[s])
      );
   end

   always_comb begin
      rd_empty = 1'b1;
      rd_data  = '0;
      for (int s = 0; s < N_SRC; s++) begin
         if (rd_sel == SEL_W'(s)) begin
            rd_empty = empties[s];
            rd_data  = empties[s] ? '0 : heads[s];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) serr_q <= 1'b0;
      else        serr_q <= serr_en && (|drops);
   end

   assign serr_evt = serr_q;
   assign full_irq = full_irq_en && (|full_stat);

   // R7: an error event always traces back to an enabled cycle
   a_r7_serr_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      serr_evt |-> $past(serr_en));

   // R7: with no drop there is no error event next cycle
   a_r7_serr_needs_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (drops == '0) |=> !serr_evt);

   // R9: an unprivileged clear write leaves every set flag in place
   a_r9_unpriv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !clr_priv) |=>
         ((full_stat & $past(full_stat)) == $past(full_stat)) &&
         ((ovf_stat & $past(ovf_stat)) == $past(ovf_stat)));

endmodule

// File: tb/cfe_fault_fifo_bank_tb_top.sv
`timescale 1ns/1ps
module cfe_fault_fifo_bank_tb_top;

   localparam int NS = 3;
   localparam int DP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        full_irq_en = 1'b0, serr_en = 1'b0;
   logic [2:0]  evt_valid = '0;
   logic [95:0] evt_addr = '0;
   logic [1:0]  rd_sel = '0;
   logic        rd_pop = 1'b0;
   logic [31:0] rd_data;
   logic        rd_empty;
   logic        clr_wr = 1'b0, clr_priv = 1'b0;
   logic [2:0]  clr_full_mask = '0, clr_ovf_mask = '0;
   logic [2:0]  full_stat, ovf_stat;
   logic        full_irq, serr_evt;

   always #4 clk = ~clk;

   cfe_fault_fifo_bank dut_i (
      .clk(clk), .rst_n(rst_n), .full_irq_en(full_irq_en), .serr_en(serr_en),
      .evt_valid(evt_valid), .evt_addr(evt_addr), .rd_sel(rd_sel), .rd_pop(rd_pop),
      .rd_data(rd_data), .rd_empty(rd_empty), .clr_wr(clr_wr), .clr_priv(clr_priv),
      .clr_full_mask(clr_full_mask), .clr_ovf_mask(clr_ovf_mask),
      .full_stat(full_stat), .ovf_stat(ovf_stat), .full_irq(full_irq), .serr_evt(serr_evt)
   );

   int n_cmp = 0, n_bad = 0;

   // Bench model of the requirements
   logic [31:0] mm [NS][DP];
   int          mc [NS];
   logic [2:0]  mf = '0, mo = '0;
   logic        ms = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R4 full_stat", {29'd0, full_stat}, {29'd0, mf});
      chk("R6 ovf_stat", {29'd0, ovf_stat}, {29'd0, mo});
      chk("R5 full_irq", {31'd0, full_irq}, {31'd0, full_irq_en & (|mf)});
      chk("R7 serr_evt", {31'd0, serr_evt}, {31'd0, ms});
      chk("R10 rd_empty", {31'd0, rd_empty}, {31'd0, mc[rd_sel] == 0});
      if (mc[rd_sel] != 0) chk("R3 rd_data", rd_data, mm[rd_sel][0]);
   endtask

   // Apply one cycle of stimulus, advance the model, compare after the edge
   task automatic step(input logic [2:0] ev, input logic [31:0] a0, a1, a2,
                       input logic pop, input logic [1:0] sel,
                       input logic cw, cp, input logic [2:0] cfm, com);
      logic [31:0] ad [NS];
      logic [2:0]  clf, clo;
      logic        anydrop;
      ad[0] = a0; ad[1] = a1; ad[2] = a2;
      evt_valid = ev; evt_addr = {a2, a1, a0}; rd_pop = pop; rd_sel = sel;
      clr_wr = cw; clr_priv = cp; clr_full_mask = cfm; clr_ovf_mask = com;
      clf = (cw && cp) ? cfm : 3'b0;
      clo = (cw && cp) ? com : 3'b0;
      anydrop = 1'b0;
      for (int s = 0; s < NS; s++) begin
         logic popok, pushok, fset, drop;
         popok  = pop && (sel == 2'(s)) && (mc[s] > 0);
         pushok = ev[s] && ((mc[s] < DP) || popok);
         drop   = ev[s] && !pushok;
         fset   = 1'b0;
         if (popok) begin
            for (int k = 0; k < DP - 1; k++) mm[s][k] = mm[s][k+1];
            mc[s]--;
         end
         if (pushok) begin
            mm[s][mc[s]] = ad[s] & 32'hFFFF_FFF8;
            mc[s]++;
            fset = (mc[s] == DP);
         end
         mf[s] = fset | (mf[s] & ~clf[s]);
         mo[s] = drop | (mo[s] & ~clo[s]);
         anydrop |= drop;
      end
      ms = serr_en & anydrop;
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(input logic [1:0] sel);
      step(3'b000, 0, 0, 0, 1'b0, sel, 1'b0, 1'b0, 3'b0, 3'b0);
   endtask

   task automatic push1(input int s, input logic [31:0] a);
      logic [2:0] ev;
      ev = 3'b001 << s;
      step(ev, a, a, a, 1'b0, 2'(s), 1'b0, 1'b0, 3'b0, 3'b0);
   endtask

   task automatic pop1(input int s);
      step(3'b000, 0, 0, 0, 1'b1, 2'(s), 1'b0, 1'b0, 3'b0, 3'b0);
   endtask

   function automatic logic [31:0] addr_of(input int s, input int i);
      return 32'h4000_0000 + (s << 20) + (i * 32'h48) + (i % 8);
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] lf;
      for (int s = 0; s < NS; s++) mc[s] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state, every source
      for (int s = 0; s < NS; s++) begin
         rd_sel = 2'(s);
         #1;
         chk("R1 rd_empty", {31'd0, rd_empty}, 32'd1);
         chk("R1 rd_data", rd_data, 32'd0);
      end
      chk("R1 flags", {26'd0, full_stat, ovf_stat}, 32'd0);
      chk("R1 outputs", {30'd0, full_irq, serr_evt}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: alignment clears bits 2:0 and keeps the rest
      push1(1, 32'hDEAD_BEEF);
      chk("R2 aligned", rd_data, 32'hDEAD_BEE8);
      pop1(1);

      // R10: pop on empty is ignored, later push reads back
      pop1(2);
      chk("R10 still empty", {31'd0, rd_empty}, 32'd1);
      push1(2, 32'h0000_1237);
      chk("R10 push after empty pop", rd_data, 32'h0000_1230);
      pop1(2);

      // R3/R4/R5: fill each source, interrupt disabled then enabled
      for (int s = 0; s < NS; s++)
         for (int i = 0; i < DP; i++) push1(s, addr_of(s, i));
      chk("R4 all full", {29'd0, full_stat}, 32'd7);
      chk("R5 irq gated off", {31'd0, full_irq}, 32'd0);
      full_irq_en = 1'b1;
      idle(2'd0);
      chk("R5 irq on", {31'd0, full_irq}, 32'd1);

      // R6/R7: overflow with error enable
      serr_en = 1'b1;
      push1(0, 32'hFFFF_FFFF);
      chk("R7 serr pulse", {31'd0, serr_evt}, 32'd1);
      chk("R6 head kept", rd_data, addr_of(0, 0) & 32'hFFFF_FFF8);
      idle(2'd0);
      chk("R7 serr one cycle", {31'd0, serr_evt}, 32'd0);
      serr_en = 1'b0;
      push1(1, 32'h1111_1111);
      chk("R7 serr disabled", {31'd0, serr_evt}, 32'd0);
      chk("R6 ovf bits", {29'd0, ovf_stat}, 32'd3);

      // R8: swap on full source 2
      step(3'b100, 0, 0, 32'h7777_777F, 1'b1, 2'd2, 1'b0, 1'b0, 3'b0, 3'b0);
      chk("R8 no overflow", {31'd0, ovf_stat[2]}, 32'd0);
      chk("R8 head advanced", rd_data, addr_of(2, 1) & 32'hFFFF_FFF8);
      for (int i = 0; i < DP; i++) pop1(2);
      chk("R8 newest drained", {31'd0, rd_empty}, 32'd1);
      chk("R4 sticky after drain", {31'd0, full_stat[2]}, 32'd1);

      // R9: unprivileged write ignored, privileged clears, set wins
      step(3'b000, 0, 0, 0, 1'b0, 2'd0, 1'b1, 1'b0, 3'b111, 3'b111);
      chk("R9 unpriv ignored", {26'd0, full_stat, ovf_stat}, {26'd0, 3'b111, 3'b011});
      step(3'b000, 0, 0, 0, 1'b0, 2'd0, 1'b1, 1'b1, 3'b100, 3'b010);
      chk("R9 masked clear", {26'd0, full_stat, ovf_stat}, {26'd0, 3'b011, 3'b001});
      pop1(0);
      step(3'b001, 32'h2222_2222, 0, 0, 1'b0, 2'd0, 1'b1, 1'b1, 3'b001, 3'b000);
      chk("R9 set wins", {31'd0, full_stat[0]}, 32'd1);
      step(3'b000, 0, 0, 0, 1'b0, 2'd0, 1'b1, 1'b1, 3'b111, 3'b111);
      chk("R5 irq drops after clear", {31'd0, full_irq}, 32'd0);

      // Near-exhaustive pseudo-random sweep, all outputs compared each cycle
      lf = 32'hACE1_1234;
      for (int c = 0; c < 4000; c++) begin
         logic [2:0] ev;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         if (c % 97 == 0) full_irq_en = lf[3];
         if (c % 61 == 0) serr_en = lf[9];
         ev = (c % 800 < 400) ? (lf[2:0] & lf[5:3]) : lf[2:0];
         step(ev, lf, {lf[15:0], lf[31:16]}, ~lf, lf[11] | lf[12],
              2'(lf[20:17] % 3), lf[25:22] == 4'd0, lf[26], lf[29:27], lf[15:13]);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule